// File: doc/BRIEF.md
# Single-Cycle 16-bit Accumulator Core

This block is a small processor core that retires one instruction per clock. It has separate ports for instruction fetch and data memory. The core holds three registers: an address/immediate register (A), a data register (D) and a 15-bit program counter (PC). There is no instruction register. The word on the instruction port is decoded in the same cycle that it is presented, and the core updates its state at the next rising edge.

There are two instruction classes. A load-immediate word puts a 15-bit constant into A. A compute word does several things in one cycle:
- it sends D and a second operand through a six-bit-controlled ALU;
- it writes the result to any subset of A, D and memory;
- it can branch to the address held in A, based on the sign and zero state of the result.

A also drives the data address, so one register serves as both the memory pointer and the branch target.

Top module: `acc16_core`

## Requirements
- R1: When bit 15 of the instruction is 0, A loads bits 14..0 zero-extended at the next rising edge. D does not change, the write strobe stays low and the PC advances by one.
- R2: When bit 15 is 1, the word is a compute instruction. Bits 14 and 13 have no effect on its behaviour.
- R3: Bit 12 selects the ALU's second operand: 0 takes A and 1 takes the data-memory read word. The first operand is always D.
- R4: Bits 11..6 control the ALU, from MSB to LSB:
  - force the first operand to zero;
  - invert the first operand;
  - force the second operand to zero;
  - invert the second operand;
  - choose add (1) or bitwise AND (0);
  - invert the output.
- R5: Bits 5, 4 and 3 enable writing the ALU result to A, D and memory respectively. Any combination is allowed. A memory write uses the A value from before the edge.
- R6: Bits 2, 1 and 0 request a branch when the result is negative, zero or positive (neither negative nor zero) respectively. On a branch the PC loads A[14:0]; otherwise it increments by one. Code 000 never branches and code 111 always branches.
- R7: The data address is always A[14:0]. Write data and the write strobe reflect the current instruction within the same cycle.
- R8: A synchronous reset clears PC, A and D to 0 and takes priority over a branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 16 | Instruction fetched from instruction memory |
| rd_data | input | 16 | Word read from data memory at mem_addr |
| wr_data | output | 16 | ALU result, the value to store |
| wr_en | output | 1 | Data-memory write strobe |
| mem_addr | output | 15 | Data-memory address (low bits of A) |
| fetch_addr | output | 15 | Instruction address (PC) |

## Verification
The outputs wr_data, wr_en and mem_addr are combinational functions of the current instruction, the read word and the register state, so they are due in the same cycle the instruction appears. The effects on A, D and PC are due one rising edge later. The bench samples every output at the falling edge, halfway between edges. At that point it compares them with its behavioural model, which has already applied the previous edge's updates. It then advances the model by one instruction before the next falling edge. Memory contents are written by the bench at the rising edge and checked after the program has settled in its halt loop.

// File: rtl/acc16_core.sv
module acc16_core #(
  parameter int DW = 16,
  parameter int PW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] instr_word,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] wr_data,
  output logic          wr_en,
  output logic [PW-1:0] mem_addr,
  output logic [PW-1:0] fetch_addr
);
  localparam int CMP_BIT = DW - 1;
  localparam int SEL_BIT = 12;

  logic [DW-1:0] a_q, d_q;
  logic [PW-1:0] pc_q;

  logic          is_cmp, sel_mem;
  logic [5:0]    op;
  logic [2:0]    dst, jc;
  logic [DW-1:0] xin, yin, xz, yz, xv, yv, sum, res;
  logic          neg, zer, pos, take;

  assign is_cmp  = instr_word[CMP_BIT];
  assign sel_mem = instr_word[SEL_BIT];
  assign op      = instr_word[11:6];
  assign dst     = instr_word[5:3];
  assign jc      = instr_word[2:0];

  assign xin = d_q;
  assign yin = sel_mem ? rd_data : a_q;

  assign xz  = op[5] ? '0 : xin;
  assign xv  = op[4] ? ~xz : xz;
  assign yz  = op[3] ? '0 : yin;
  assign yv  = op[2] ? ~yz : yz;
  assign sum = op[1] ? (xv + yv) : (xv & yv);
  assign res = op[0] ? ~sum : sum;

  assign neg  = res[DW-1];
  assign zer  = (res == '0);
  assign pos  = !neg && !zer;
  assign take = is_cmp && ((jc[2] && neg) || (jc[1] && zer) || (jc[0] && pos));

  assign wr_data    = res;
  assign wr_en      = is_cmp && dst[0];
  assign mem_addr   = a_q[PW-1:0];
  assign fetch_addr = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      d_q  <= '0;
      pc_q <= '0;
    end else begin
      if (!is_cmp)
        a_q <= {{(DW-PW){1'b0}}, instr_word[PW-1:0]};
      else if (dst[2])
        a_q <= res;
      if (is_cmp && dst[1])
        d_q <= res;
      pc_q <= take ? a_q[PW-1:0] : pc_q + {{(PW-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/acc16_core_chk.sv
module acc16_core_chk #(
  parameter int DW = 16,
  parameter int PW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] instr_word,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] wr_data,
  input logic          wr_en,
  input logic [PW-1:0] mem_addr,
  input logic [PW-1:0] fetch_addr
);
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0) && (mem_addr == '0));

  a_r1_ldi_no_write: assert property (@(posedge clk) disable iff (rst)
    !instr_word[DW-1] |-> !wr_en);

  a_r1_ldi_loads_a: assert property (@(posedge clk) disable iff (rst)
    !instr_word[DW-1] |=> mem_addr == $past(instr_word[PW-1:0]));

  a_r5_mem_write_gated: assert property (@(posedge clk) disable iff (rst)
    (instr_word[DW-1] && !instr_word[3]) |-> !wr_en);

  a_r6_no_branch_steps: assert property (@(posedge clk) disable iff (rst)
    (!instr_word[DW-1] || instr_word[2:0] == 3'b000) |=>
      fetch_addr == PW'($past(fetch_addr) + PW'(1)));

  a_r6_always_branch: assert property (@(posedge clk) disable iff (rst)
    (instr_word[DW-1] && instr_word[2:0] == 3'b111) |=>
      fetch_addr == $past(mem_addr));
endmodule

bind acc16_core acc16_core_chk #(.DW(DW), .PW(PW)) u_chk (.*);

// File: tb/sim_acc16_core.sv
`timescale 1ns/1ps
module sim_acc16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word, rd_data, wr_data;
  logic        wr_en;
  logic [14:0] mem_addr, fetch_addr;

  logic [15:0] rom [128];
  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  logic [15:0] ref_a, ref_d;
  logic [14:0] ref_pc;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc16_core u0 (.clk(clk), .rst(rst), .instr_word(instr_word), .rd_data(rd_data),
                 .wr_data(wr_data), .wr_en(wr_en), .mem_addr(mem_addr),
                 .fetch_addr(fetch_addr));

  assign instr_word = rom[fetch_addr[6:0]];
  assign rd_data    = mem[mem_addr[7:0]];

  always @(posedge clk) if (wr_en && !rst) mem[mem_addr[7:0]] <= wr_data;

  function automatic logic [15:0] ldi(input int v);
    return {1'b0, 15'(v)};
  endfunction

  function automatic logic [15:0] cmp(input logic [1:0] u, input logic a, input logic [5:0] c,
                                      input logic [2:0] dd, input logic [2:0] j);
    return {1'b1, u, a, c, dd, j};
  endfunction

  // Reference ALU by mnemonic table (R4)
  function automatic logic [15:0] ref_alu(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
    case (c)
      6'b101010: return 16'd0;
      6'b111111: return 16'd1;
      6'b111010: return 16'hFFFF;
      6'b001100: return x;
      6'b110000: return y;
      6'b001101: return ~x;
      6'b110001: return ~y;
      6'b001111: return -x;
      6'b110011: return -y;
      6'b011111: return x + 16'd1;
      6'b110111: return y + 16'd1;
      6'b001110: return x - 16'd1;
      6'b110010: return y - 16'd1;
      6'b000010: return x + y;
      6'b010011: return x - y;
      6'b000111: return y - x;
      6'b000000: return x & y;
      6'b010101: return x | y;
      default:   return 16'hxxxx;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ref_reset();
    ref_a = '0; ref_d = '0; ref_pc = '0;
  endtask

  // Compare current outputs, then advance the model one instruction.
  task automatic compare_and_step();
    logic [15:0] iw, y, r;
    logic        jmp;
    iw = rom[ref_pc[6:0]];
    chk(fetch_addr === ref_pc, "R6 pc", {1'b0, fetch_addr}, {1'b0, ref_pc});
    chk(mem_addr === ref_a[14:0], "R7 data address", {1'b0, mem_addr}, {1'b0, ref_a[14:0]});
    if (!iw[15]) begin
      chk(wr_en === 1'b0, "R1 no write on load", {15'd0, wr_en}, 16'd0);
      ref_a  = {1'b0, iw[14:0]};
      ref_pc = ref_pc + 15'd1;
    end else begin
      y = iw[12] ? ref_mem[ref_a[7:0]] : ref_a;   // R3
      r = ref_alu(iw[11:6], ref_d, y);
      chk(wr_en === iw[3], "R5 write strobe", {15'd0, wr_en}, {15'd0, iw[3]});
      chk(wr_data === r, "R4 result", wr_data, r);
      case (iw[2:0])
        3'd0: jmp = 0;
        3'd1: jmp = $signed(r) > 0;
        3'd2: jmp = r == 0;
        3'd3: jmp = $signed(r) >= 0;
        3'd4: jmp = $signed(r) < 0;
        3'd5: jmp = r != 0;
        3'd6: jmp = $signed(r) <= 0;
        default: jmp = 1;
      endcase
      ref_pc = jmp ? ref_a[14:0] : ref_pc + 15'd1;
      if (iw[3]) ref_mem[ref_a[7:0]] = r;
      if (iw[5]) ref_a = r;
      if (iw[4]) ref_d = r;
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      compare_and_step();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    ref_reset();
    chk(fetch_addr === 15'd0, "R8 pc after reset", {1'b0, fetch_addr}, 16'd0);
    chk(mem_addr === 15'd0, "R8 A after reset", {1'b0, mem_addr}, 16'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    for (int i = 0; i < 128; i++) rom[i] = '0;
    mem[0] = 16'd10; ref_mem[0] = 16'd10;
    // Program 1: sum 1..RAM[0] into RAM[1]
    rom[0]  = ldi(16);
    rom[1]  = cmp(2'b11, 0, 6'b111111, 3'b001, 3'b000);
    rom[2]  = ldi(17);
    rom[3]  = cmp(2'b11, 0, 6'b101010, 3'b001, 3'b000);
    rom[4]  = ldi(16);
    rom[5]  = cmp(2'b11, 1, 6'b110000, 3'b010, 3'b000);
    rom[6]  = ldi(0);
    rom[7]  = cmp(2'b11, 1, 6'b010011, 3'b010, 3'b000);
    rom[8]  = ldi(18);
    rom[9]  = cmp(2'b11, 0, 6'b001100, 3'b000, 3'b001);
    rom[10] = ldi(16);
    rom[11] = cmp(2'b11, 1, 6'b110000, 3'b010, 3'b000);
    rom[12] = ldi(17);
    rom[13] = cmp(2'b11, 1, 6'b000010, 3'b001, 3'b000);
    rom[14] = ldi(16);
    rom[15] = cmp(2'b11, 1, 6'b110111, 3'b001, 3'b000);
    rom[16] = ldi(4);
    rom[17] = cmp(2'b11, 0, 6'b101010, 3'b000, 3'b111);
    rom[18] = ldi(17);
    rom[19] = cmp(2'b11, 1, 6'b110000, 3'b010, 3'b000);
    rom[20] = ldi(1);
    rom[21] = cmp(2'b11, 0, 6'b001100, 3'b001, 3'b000);
    rom[22] = ldi(22);
    rom[23] = cmp(2'b11, 0, 6'b101010, 3'b000, 3'b111);

    @(negedge clk);
    do_reset();
    run(220);
    chk(mem[1] === 16'd55, "R5 sum stored", mem[1], 16'd55);
    chk(mem[17] === ref_mem[17], "R3 sum variable", mem[17], ref_mem[17]);

    // R8: reset while the halt loop's branch is pending
    while (fetch_addr != 15'd23) begin compare_and_step(); @(negedge clk); end
    rst = 1'b1;
    @(negedge clk);
    chk(fetch_addr === 15'd0, "R8 reset beats branch", {1'b0, fetch_addr}, 16'd0);

    // Program 2: every branch code against negative, zero and positive results
    for (int i = 0; i < 128; i++) rom[i] = '0;
    for (int v = 0; v < 3; v++)
      for (int j = 0; j < 8; j++) begin
        int b;
        b = (v * 8 + j) * 4;
        rom[b]   = cmp(2'b11, 0, (v == 0) ? 6'b111010 : (v == 1) ? 6'b101010 : 6'b111111, 3'b010, 3'b000);
        rom[b+1] = ldi(b + 4);
        rom[b+2] = cmp(2'b11, 0, 6'b001100, 3'b000, 3'(j));   // R6
        rom[b+3] = cmp(2'b00, 0, 6'b001100, 3'b010, 3'b000);  // R2 unused bits cleared
      end
    rom[96]  = cmp(2'b01, 0, 6'b111111, 3'b010, 3'b000);
    rom[97]  = ldi(100);
    rom[98]  = cmp(2'b10, 0, 6'b011111, 3'b111, 3'b000);
    rom[99]  = ldi(99);
    rom[100] = cmp(2'b11, 0, 6'b101010, 3'b000, 3'b111);
    do_reset();
    run(140);
    chk(mem[100] === 16'd2, "R5 write uses old A", mem[100], 16'd2);
    chk(fetch_addr === 15'd99 || fetch_addr === 15'd100, "R6 halt loop reached",
        {1'b0, fetch_addr}, 16'd99);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule